// File: doc/BRIEF.md
# External Data Memory Address Router

This block sits between a small microcontroller core and its byte-wide data memory. Each access the core issues is sent either to an on-chip RAM held inside the block or to an off-chip address bus. The choice depends on the effective address and on a 2-bit routing mode supplied with the request.

An access names its address in one of two forms:

- **Short form:** a page byte supplies the upper half of the address and a pointer byte supplies the lower half.
- **Long form:** a 16-bit data pointer supplies the whole address.

The off-chip bus has a separate drive enable for each address byte. In one split mode a short-form access leaves the upper byte undriven, so that port latches outside the block keep control of it.

Every request finishes in one cycle. The block asserts `done` for one cycle on the clock after the request and presents registered read data at that time. A two-state controller tracks completion:

- `ST_IDLE` moves to `ST_DONE` when a request is seen at a clock edge.
- `ST_DONE` stays in `ST_DONE` if another request is present.
- `ST_DONE` falls back to `ST_IDLE` when no request is present.

Top module: `xmem_router`

## Requirements
- R1: While reset is held and while no request is present after reset, `done` is 0, `rdata` is 0 after reset, and `ext_rd`, `ext_wr`, `ext_addr_hi_en` and `ext_addr_lo_en` are all 0.
- R2: With `cfg_mode` = 2'b00, every access goes to the on-chip RAM, no off-chip strobe or enable is raised, and the address is taken modulo 8192, so 0x1000 and 0x2000 reach the same locations as 0x1000 and 0x0000 respectively.
- R3: With `wide` = 0 the effective address is {`page`, `ptr`} and `dptr` is ignored. With `wide` = 1 the effective address is `dptr`, and `page` and `ptr` are ignored.
- R4: With `cfg_mode` = 2'b01 or 2'b10, an effective address below 0x2000 goes on-chip and an address of 0x2000 or above goes off-chip. An off-chip access raises `ext_rd` (when `we` = 0) or `ext_wr` (when `we` = 1) during the request cycle.
- R5: With `cfg_mode` = 2'b01, an off-chip short-form access drives `ext_addr[7:0]` = `ptr` with `ext_addr_lo_en` = 1, holds `ext_addr_hi_en` = 0, and leaves `ext_addr[15:8]` at 0.
- R6: With `cfg_mode` = 2'b10 or 2'b11, an off-chip short-form access drives `ext_addr` = {`page`, `ptr`} with both enables set.
- R7: In every mode, an off-chip long-form access drives `ext_addr` = `dptr` with both enables set.
- R8: With `cfg_mode` = 2'b11, every access goes off-chip, including addresses below 0x2000.
- R9: `done` is 1 in the cycle after each cycle in which `req` is 1, and 0 otherwise. On a read, `rdata` in the `done` cycle holds the byte from the selected target. For an off-chip read this is `ext_rdata` as sampled at the request edge.
- R10: An on-chip write takes effect at the clock edge of its request, and a read in the next cycle returns the new byte. An off-chip write presents `wdata` on `ext_wdata` during the request cycle and leaves the on-chip RAM unchanged.
- R11: The mode is applied per request. In back-to-back requests, a change of `cfg_mode` alters the routing of the later request only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Routing mode: 00 on-chip only, 01 split with upper byte undriven, 10 split with page on the upper byte, 11 off-chip only |
| req | input | 1 | Access request, one access per cycle in which it is high |
| wide | input | 1 | 1 selects the long form (`dptr`), 0 selects the short form (`page`, `ptr`) |
| we | input | 1 | 1 write, 0 read |
| page | input | 8 | Upper address byte for short-form accesses |
| ptr | input | 8 | Lower address byte for short-form accesses |
| dptr | input | 16 | Full address for long-form accesses |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, valid while `done` is 1 after a read |
| done | output | 1 | One-cycle completion pulse |
| ext_addr | output | 16 | Off-chip address bus value |
| ext_addr_hi_en | output | 1 | Drive enable for `ext_addr[15:8]` |
| ext_addr_lo_en | output | 1 | Drive enable for `ext_addr[7:0]` |
| ext_wdata | output | 8 | Off-chip write data, 0 when no off-chip write |
| ext_wr | output | 1 | Off-chip write strobe |
| ext_rd | output | 1 | Off-chip read strobe |
| ext_rdata | input | 8 | Off-chip read data, sampled at the request edge |

## Verification
The hardest case to reach from the ports is proving that an off-chip write leaves no trace in the on-chip RAM. The address of such a write aliases an on-chip location modulo 8192, yet nothing at the ports shows a missed or stray write until that location is read again in the on-chip-only mode.

The stimulus proceeds in three steps:

1. It fills all 8192 on-chip locations with known bytes.
2. It sweeps both address forms and both directions across the three off-chip-capable modes, including the 0x1FFF/0x2000 boundary and the address extremes.
3. It rereads a strided set of on-chip locations against a shadow copy that only on-chip writes have updated.

A separate back-to-back sequence flips the mode between two consecutive requests to the same address. It also reads a location in the cycle right after writing it.

// File: rtl/xr_pkg.sv
package xr_pkg;

    typedef enum logic [1:0] {
        MODE_INT_ONLY     = 2'b00,
        MODE_SPLIT_NOBANK = 2'b01,
        MODE_SPLIT_BANK   = 2'b10,
        MODE_EXT_ONLY     = 2'b11
    } xr_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } xr_state_e;

endpackage

// File: rtl/xr_decode.sv
module xr_decode
    import xr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int INT_AW = 13
) (
    input  xr_mode_e             mode,
    input  logic                 wide,
    input  logic [ADDR_W/2-1:0]  page,
    input  logic [ADDR_W/2-1:0]  ptr,
    input  logic [ADDR_W-1:0]    dptr,
    output logic [ADDR_W-1:0]    ea,
    output logic                 offchip,
    output logic                 hi_en,
    output logic                 lo_en
);

    logic above;

    always_comb begin
        ea    = wide ? dptr : {page, ptr};
        above = |ea[ADDR_W-1:INT_AW];
    end

    always_comb begin
        offchip = 1'b0;
        hi_en   = 1'b0;
        unique case (mode)
            MODE_INT_ONLY: begin
                offchip = 1'b0;
                hi_en   = 1'b0;
            end
            MODE_SPLIT_NOBANK: begin
                offchip = above;
                hi_en   = above & wide;
            end
            MODE_SPLIT_BANK: begin
                offchip = above;
                hi_en   = above;
            end
            MODE_EXT_ONLY: begin
                offchip = 1'b1;
                hi_en   = 1'b1;
            end
            default: begin
                offchip = 1'b0;
                hi_en   = 1'b0;
            end
        endcase
        lo_en = offchip;
    end

endmodule

// File: rtl/xr_iram.sv
module xr_iram #(
    parameter int INT_AW = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [INT_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << INT_AW;

    logic [DATA_W-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/xr_ctrl.sv
module xr_ctrl
    import xr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              offchip,
    input  logic [DATA_W-1:0] int_rdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    xr_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = req ? ST_DONE : ST_IDLE;
            ST_DONE: nxt = req ? ST_DONE : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (req && !we) begin
            rdata <= offchip ? ext_rdata : int_rdata;
        end
    end

    always_comb begin
        done = (state == ST_DONE);
    end

    // R9
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> done);

    // R9
    done_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !done);

endmodule

// File: rtl/xmem_router.sv
module xmem_router
    import xr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int INT_AW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              req,
    input  logic              wide,
    input  logic              we,
    input  logic [7:0]        page,
    input  logic [7:0]        ptr,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_addr_hi_en,
    output logic              ext_addr_lo_en,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_wr,
    output logic              ext_rd,
    input  logic [DATA_W-1:0] ext_rdata
);

    localparam int HALF = ADDR_W / 2;

    xr_mode_e          mode;
    logic [ADDR_W-1:0] ea;
    logic              offchip, hi_en, lo_en;
    logic              int_wr;
    logic [DATA_W-1:0] int_rdata;

    assign mode = xr_mode_e'(cfg_mode);

    xr_decode #(.ADDR_W(ADDR_W), .INT_AW(INT_AW)) u_decode (
        .mode    (mode),
        .wide    (wide),
        .page    (page),
        .ptr     (ptr),
        .dptr    (dptr),
        .ea      (ea),
        .offchip (offchip),
        .hi_en   (hi_en),
        .lo_en   (lo_en)
    );

    assign int_wr = req & we & ~offchip;

    xr_iram #(.INT_AW(INT_AW), .DATA_W(DATA_W)) u_iram (
        .clk   (clk),
        .wr_en (int_wr),
        .addr  (ea[INT_AW-1:0]),
        .wdata (wdata),
        .rdata (int_rdata)
    );

    xr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .we        (we),
        .offchip   (offchip),
        .int_rdata (int_rdata),
        .ext_rdata (ext_rdata),
        .done      (done),
        .rdata     (rdata)
    );

    always_comb begin
        ext_rd         = req & ~we & offchip;
        ext_wr         = req & we & offchip;
        ext_addr_hi_en = req & hi_en;
        ext_addr_lo_en = req & lo_en;
        ext_addr[ADDR_W-1:HALF] = ext_addr_hi_en ? ea[ADDR_W-1:HALF] : '0;
        ext_addr[HALF-1:0]      = ext_addr_lo_en ? ea[HALF-1:0] : '0;
        ext_wdata      = ext_wr ? wdata : '0;
    end

    // R2
    int_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cfg_mode == 2'b00) |-> (!ext_rd && !ext_wr && !ext_addr_lo_en && !ext_addr_hi_en));

    // R4
    split_low_onchip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wide && (cfg_mode == 2'b01 || cfg_mode == 2'b10) && dptr < (1 << INT_AW))
            |-> (!ext_rd && !ext_wr));

    // R5
    nobank_hi_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wide && cfg_mode == 2'b01 && (ext_rd || ext_wr))
            |-> (!ext_addr_hi_en && ext_addr_lo_en && ext_addr[ADDR_W-1:HALF] == '0));

    // R7
    wide_full_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && wide && (ext_rd || ext_wr))
            |-> (ext_addr_hi_en && ext_addr_lo_en && ext_addr == dptr));

    // R8
    ext_only_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cfg_mode == 2'b11) |-> (ext_rd || ext_wr));

    // R6
    hi_needs_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_addr_hi_en |-> ext_addr_lo_en);

endmodule

// File: tb/xmem_router_tb.sv
`timescale 1ns/1ps
module xmem_router_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'b00;
    logic        req = 1'b0;
    logic        wide = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  page = 8'h00;
    logic [7:0]  ptr = 8'h00;
    logic [15:0] dptr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        done;
    logic [15:0] ext_addr;
    logic        ext_addr_hi_en, ext_addr_lo_en;
    logic [7:0]  ext_wdata;
    logic        ext_wr, ext_rd;
    logic [7:0]  ext_rdata;

    int checks = 0;
    int failures = 0;
    logic [7:0] shadow [0:8191];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] ext_model(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hC3;
    endfunction

    assign ext_rdata = ext_model(ext_addr);

    xmem_router u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .req(req), .wide(wide),
        .we(we), .page(page), .ptr(ptr), .dptr(dptr), .wdata(wdata),
        .rdata(rdata), .done(done), .ext_addr(ext_addr),
        .ext_addr_hi_en(ext_addr_hi_en), .ext_addr_lo_en(ext_addr_lo_en),
        .ext_wdata(ext_wdata), .ext_wr(ext_wr), .ext_rd(ext_rd),
        .ext_rdata(ext_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] m, input logic w, input logic wr,
                          input logic [7:0] pg, input logic [7:0] pt,
                          input logic [15:0] dp, input logic [7:0] wd);
        logic [15:0] ea, ea_exp;
        logic off, hi;
        logic [7:0] exp_rd;
        string rtag, atag;
        ea  = w ? dp : {pg, pt};
        off = (m == 2'b11) || ((m == 2'b01 || m == 2'b10) && ea >= 16'h2000);
        hi  = off && (w || m != 2'b01);
        ea_exp = {hi ? ea[15:8] : 8'h00, off ? ea[7:0] : 8'h00};
        rtag = (m == 2'b00) ? "R2" : (m == 2'b11) ? "R8" : "R4";
        atag = w ? "R7" : (m == 2'b01) ? "R5" : "R6";
        @(negedge clk);
        chk(done == 1'b0, "R9 idle done", done, 0);
        cfg_mode = m; wide = w; we = wr; page = pg; ptr = pt; dptr = dp; wdata = wd;
        req = 1'b1;
        #1;
        chk(ext_rd == (off && !wr), rtag, ext_rd, off && !wr);
        chk(ext_wr == (off && wr), rtag, ext_wr, off && wr);
        chk(ext_addr_lo_en == off, atag, ext_addr_lo_en, off);
        chk(ext_addr_hi_en == hi, atag, ext_addr_hi_en, hi);
        if (off) begin
            chk(ext_addr == ea_exp, "R3 address", ext_addr, ea_exp);
            if (wr) chk(ext_wdata == wd, "R10 ext wdata", ext_wdata, wd);
        end
        exp_rd = off ? ext_model(ea_exp) : shadow[ea[12:0]];
        @(negedge clk);
        req = 1'b0;
        chk(done == 1'b1, "R9 done", done, 1);
        if (!wr) chk(rdata == exp_rd, "R9 rdata", rdata, exp_rd);
        else if (!off) shadow[ea[12:0]] = wd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [7:0] pg, pt, wd;
        logic [15:0] dp;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(ext_rd == 1'b0 && ext_wr == 1'b0, "R1 strobes", {ext_rd, ext_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdata == 8'h00, "R1 rdata", rdata, 0);
        chk(ext_addr_hi_en == 1'b0 && ext_addr_lo_en == 1'b0, "R1 enables",
            {ext_addr_hi_en, ext_addr_lo_en}, 0);

        // fill on-chip RAM in internal-only mode (R2)
        for (int i = 0; i < 8192; i++) begin
            a = 16'(i);
            access(2'b00, 1'b1, 1'b1, 8'h00, 8'h00, a, 8'(i * 7 + (i >> 8)));
        end

        // wrapped reads in internal-only mode, both forms (R2, R3)
        for (int i = 0; i < 65536; i += 37) begin
            a = 16'(i);
            access(2'b00, 1'b1, 1'b0, ~a[15:8], ~a[7:0], a, 8'h00);
            access(2'b00, 1'b0, 1'b0, a[15:8], a[7:0], ~a, 8'h00);
        end

        // split and off-chip modes, both forms, both directions
        for (int m = 1; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                for (int wr = 0; wr < 2; wr++) begin
                    for (int k = 0; k < 266; k++) begin
                        case (k)
                            262: a = 16'h1FFF;
                            263: a = 16'h2000;
                            264: a = 16'h0000;
                            265: a = 16'hFFFF;
                            default: a = 16'(k * 251);
                        endcase
                        if (w == 1) begin
                            dp = a; pg = ~a[15:8]; pt = ~a[7:0];
                        end else begin
                            dp = ~a; pg = a[15:8]; pt = a[7:0];
                        end
                        wd = wr[0] ? (a[7:0] ^ 8'h96 ^ 8'(k)) : 8'h00;
                        access(2'(m), w[0], wr[0], pg, pt, dp, wd);
                    end
                end
            end
        end

        // R10: off-chip writes must not have disturbed on-chip RAM
        for (int i = 0; i < 8192; i += 7) begin
            a = 16'(i);
            @(negedge clk);
            cfg_mode = 2'b00; wide = 1'b1; we = 1'b0; dptr = a; req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            chk(rdata == shadow[i], "R10 readback", rdata, shadow[i]);
        end

        // R11 / R10: back-to-back requests with mode change
        @(negedge clk);
        cfg_mode = 2'b00; wide = 1'b1; we = 1'b1; dptr = 16'h0ABC; wdata = 8'h5E; req = 1'b1;
        @(negedge clk);
        shadow[13'h0ABC] = 8'h5E;
        chk(done == 1'b1, "R9 back-to-back done", done, 1);
        cfg_mode = 2'b11; we = 1'b0;
        #1;
        chk(ext_rd == 1'b1, "R11 later mode routes off-chip", ext_rd, 1);
        chk(ext_addr == 16'h0ABC, "R11 address", ext_addr, 16'h0ABC);
        @(negedge clk);
        chk(rdata == ext_model(16'h0ABC), "R11 off-chip rdata", rdata, ext_model(16'h0ABC));
        cfg_mode = 2'b00;
        #1;
        chk(ext_rd == 1'b0, "R11 back to on-chip", ext_rd, 0);
        @(negedge clk);
        req = 1'b0;
        chk(done == 1'b1, "R9 done held", done, 1);
        chk(rdata == 8'h5E, "R10 write then read", rdata, 8'h5E);
        @(negedge clk);
        chk(done == 1'b0, "R9 done drops", done, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule